// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the write-only control port of a signal-conditioning front end. An external controller drives three wires: a serial clock, a data line and an active-low load strobe. While the strobe is low, each rising serial clock edge shifts in one bit. A frame starts with a reserved bit that must be zero. A 3-bit start address follows, least significant bit first. Then come one or more 12-bit data words, each least significant bit first.

Words are staged as they complete, and each complete word advances the address by one. Nothing reaches the active registers until the strobe rises. At that point every staged word is committed together. Four registers are exposed:
- address 0: an operation word, whose bit 0 requests a return to defaults;
- address 1: a control word;
- address 2: an 8-bit clamp level;
- address 3: a 10-bit gain code.

The operation word also drives a power mode field, a clamp-disable flag and a blanking-level flag. After reset, a calibration lockout runs for a parameterized number of system clock cycles, and serial writes are ignored until it ends. The three serial inputs are synchronized into the system clock domain. The serial clock may run at up to a quarter of the system clock rate.

Top module: `serial_cfg_port`

## Requirements
- R1: A bit is captured on each synchronized rising edge of `ser_clk` while `ser_load_n` is low. Frame order is: reserved bit, address bits A0 A1 A2, then data bits D0..D11 of each word, all least significant bit first.
- R2: Active registers change only in response to a rising edge of `ser_load_n`. A frame that is complete but not yet closed leaves all outputs unchanged.
- R3: While the strobe stays low, each further 12-bit word is written to the next address (start, start+1, start+2, ...).
- R4: The address is 3 bits wide and wraps from 7 to 0. A word aimed at address 4..7 is discarded, but it still advances the address.
- R5: After `rst`: `reg_oper`=0, `reg_ctrl`=0, `reg_clamp`=128, `reg_gain`=0, and `cal_busy`=1.
- R6: Committing an operation word with bit 0 set returns every register to its R5 value. This also overrides the other words committed in the same frame.
- R7: `cal_busy` stays high for `LOCK_CYCLES` cycles after reset and never rises again. While it is high, frames and strobe edges have no effect.
- R8: A frame whose reserved bit is 1 is discarded entirely.
- R9: `reg_clamp` keeps data bits D7..D0 of its word, and `reg_gain` keeps D9..D0. Higher bits are dropped.
- R10: The decoded outputs follow the operation word: `pwr_mode`=bits 2:1 (00 normal, 01 standby, 10 shutdown), `clamp_off`=bit 3, `blank_lvl`=bit 6.
- R11: A word with fewer than 12 data bits when the strobe rises is discarded. Complete words earlier in the same frame still commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_load_n | input | 1 | Load strobe, low during a frame; its rising edge commits |
| reg_oper | output | 12 | Active operation word |
| reg_ctrl | output | 12 | Active control word |
| reg_clamp | output | 8 | Active clamp level |
| reg_gain | output | 10 | Active gain code |
| pwr_mode | output | 2 | Power mode field of the operation word |
| clamp_off | output | 1 | Clamp disable flag |
| blank_lvl | output | 1 | Blanking level select |
| cal_busy | output | 1 | High during the post-reset lockout |

## Verification
The bench drives frames of several shapes, and each shape separates one class of fault:
- Single-word writes to different addresses expose bit-order and address-decode faults.
- A three-word burst shows whether the auto-increment works.
- Bursts that start at 3 and at 7 show whether out-of-range words are dropped while the address still advances and wraps.

Further frames cover the remaining rules:
- A frame held open before the strobe rises, and a frame that ends mid-word, separate staging from committing.
- Frames with the reserved bit set, frames sent during the lockout, and a frame that combines a reset request with other data show that each of these is ignored or overridden as required.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int NUM_REGS = 4;

  typedef enum logic [1:0] {ST_TEST, ST_ADDR, ST_DATA, ST_DROP} rx_state_t;

  // width of register i: 2 = clamp, 3 = gain, others full word
  function automatic int fld_w(input int i, input int dw, input int cw, input int gw);
    return (i == 2) ? cw : (i == 3) ? gw : dw;
  endfunction

  function automatic int fld_off(input int i, input int dw, input int cw, input int gw);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += fld_w(j, dw, cw, gw);
    return s;
  endfunction
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state   <= ST_TEST;
      cnt     <= '0;
      addr    <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (bit_stb) begin
        case (state)
          ST_TEST: begin
            state <= bit_val ? ST_DROP : ST_ADDR;
            cnt   <= '0;
          end
          ST_ADDR: begin
            addr <= {bit_val, addr[ADDR_W-1:1]};
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              state <= ST_DATA;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            wr_data <= {bit_val, wr_data[DATA_W-1:1]};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt     <= '0;
              wr_stb  <= 1'b1;
              wr_addr <= addr;
              addr    <= addr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_DROP;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 12,
  parameter int CLAMP_W   = 8,
  parameter int GAIN_W    = 10,
  parameter int CLAMP_RST = 128,
  localparam int TOT_W    = fld_off(NUM_REGS, DATA_W, CLAMP_W, GAIN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [TOT_W-1:0]  act_flat
);
  logic soft_rst;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int W   = fld_w(i, DATA_W, CLAMP_W, GAIN_W);
    localparam int OFF = fld_off(i, DATA_W, CLAMP_W, GAIN_W);
    localparam logic [W-1:0] DEF = (i == 2) ? W'(CLAMP_RST) : '0;

    logic [W-1:0] st;
    logic [W-1:0] act;
    logic         pend;

    always_ff @(posedge clk) begin
      if (rst || commit) begin
        pend <= 1'b0;
        st   <= '0;
      end else if (wr_stb && wr_addr == ADDR_W'(i)) begin
        pend <= 1'b1;
        st   <= wr_data[W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || (commit && soft_rst)) act <= DEF;
      else if (commit && pend)         act <= st;
    end

    assign act_flat[OFF +: W] = act;
  end

  assign soft_rst = g_reg[0].pend & g_reg[0].st[0];
endmodule

// File: rtl/cfg_cal_timer.sv
module cfg_cal_timer #(
  parameter int LOCK_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LOCK_CYCLES - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 12,
  parameter int CLAMP_W     = 8,
  parameter int GAIN_W      = 10,
  parameter int CLAMP_RST   = 128,
  parameter int LOCK_CYCLES = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_load_n,
  output logic [DATA_W-1:0]  reg_oper,
  output logic [DATA_W-1:0]  reg_ctrl,
  output logic [CLAMP_W-1:0] reg_clamp,
  output logic [GAIN_W-1:0]  reg_gain,
  output logic [1:0]         pwr_mode,
  output logic               clamp_off,
  output logic               blank_lvl,
  output logic               cal_busy
);
  localparam int TOT_W = fld_off(NUM_REGS, DATA_W, CLAMP_W, GAIN_W);

  // bit 0 serial clock, bit 1 load strobe, bit 2 data
  logic [2:0] meta, sync;
  logic [1:0] prev;
  logic       sck_rise, load_rise, bit_stb, commit, rx_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 3'b010;
      sync <= 3'b010;
      prev <= 2'b10;
    end else begin
      meta <= {ser_data, ser_load_n, ser_clk};
      sync <= meta;
      prev <= sync[1:0];
    end
  end

  assign sck_rise  = sync[0] & ~prev[0];
  assign load_rise = sync[1] & ~prev[1];
  assign bit_stb   = sck_rise & ~sync[1] & ~cal_busy;
  assign rx_clr    = sync[1] | cal_busy;
  assign commit    = load_rise & ~cal_busy;

  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [TOT_W-1:0]  act_flat;

  cfg_cal_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .busy(cal_busy)
  );

  cfg_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .bit_stb(bit_stb), .bit_val(sync[2]),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cfg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLAMP_W(CLAMP_W),
    .GAIN_W(GAIN_W), .CLAMP_RST(CLAMP_RST)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .act_flat(act_flat)
  );

  assign reg_oper  = act_flat[0 +: DATA_W];
  assign reg_ctrl  = act_flat[DATA_W +: DATA_W];
  assign reg_clamp = act_flat[2*DATA_W +: CLAMP_W];
  assign reg_gain  = act_flat[2*DATA_W+CLAMP_W +: GAIN_W];
  assign pwr_mode  = reg_oper[2:1];
  assign clamp_off = reg_oper[3];
  assign blank_lvl = reg_oper[6];
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int TOT_W = 42
) (
  input logic             clk,
  input logic             rst,
  input logic             commit,
  input logic             cal_busy,
  input logic [TOT_W-1:0] regs
);
  // R2
  no_commit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(regs));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> $stable(regs));

  // R7
  busy_once_chk: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |=> !cal_busy);

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !regs[0]);
endmodule

bind serial_cfg_port cfg_port_chk #(.TOT_W(TOT_W)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .cal_busy(cal_busy), .regs(act_flat)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
  logic clk = 0, rst = 1;
  logic sck = 0, sdat = 0, sload = 1;
  logic [11:0] oper, ctrl;
  logic [7:0]  clamp;
  logic [9:0]  gain;
  logic [1:0]  pmode;
  logic        coff, blvl, busy;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  serial_cfg_port #(.LOCK_CYCLES(400)) u0 (
    .clk(clk), .rst(rst), .ser_clk(sck), .ser_data(sdat), .ser_load_n(sload),
    .reg_oper(oper), .reg_ctrl(ctrl), .reg_clamp(clamp), .reg_gain(gain),
    .pwr_mode(pmode), .clamp_off(coff), .blank_lvl(blvl), .cal_busy(busy)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdat = b; waitc(4);
    sck = 1;  waitc(4);
    sck = 0;
  endtask

  task automatic open_frame(input logic tbit, input logic [2:0] a);
    sload = 0; waitc(4);
    send_bit(tbit);
    for (int i = 0; i < 3; i++) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 0; i < 12; i++) send_bit(w[i]);
  endtask

  task automatic close_frame();
    waitc(4); sload = 1; waitc(12);
  endtask

  task automatic write1(input logic [2:0] a, input logic [11:0] w);
    open_frame(1'b0, a); send_word(w); close_frame();
  endtask

  task automatic t_reset();
    check("R5 oper", oper, 0);
    check("R5 ctrl", ctrl, 0);
    check("R5 clamp", clamp, 128);
    check("R5 gain", gain, 0);
    check("R5 R7 busy", busy, 1);
  endtask

  task automatic t_lockout();
    write1(3'd3, 12'h155);
    check("R7 ignored during lockout", gain, 0);
    check("R7 still busy", busy, 1);
    while (busy) waitc(1);
    waitc(20);
    check("R7 stays low", busy, 0);
  endtask

  task automatic t_single();
    write1(3'd3, 12'h2A5);
    check("R1 gain", gain, 'h2A5);
    write1(3'd1, 12'hABC);
    check("R1 ctrl", ctrl, 'hABC);
  endtask

  task automatic t_commit_gate();
    open_frame(1'b0, 3'd2); send_word(12'h03C);
    waitc(30);
    check("R2 held before strobe", clamp, 128);
    close_frame();
    check("R2 after strobe", clamp, 'h3C);
  endtask

  task automatic t_autoinc();
    open_frame(1'b0, 3'd1);
    send_word(12'h123); send_word(12'h045); send_word(12'h3FF);
    close_frame();
    check("R3 ctrl", ctrl, 'h123);
    check("R3 clamp", clamp, 'h45);
    check("R3 gain", gain, 'h3FF);
  endtask

  task automatic t_high_addr();
    open_frame(1'b0, 3'd3); send_word(12'h011); send_word(12'h777); close_frame();
    check("R4 addr3 then dropped", gain, 'h011);
    check("R4 ctrl untouched", ctrl, 'h123);
    open_frame(1'b0, 3'd7); send_word(12'h999); send_word(12'h048); close_frame();
    check("R4 wrap to 0", oper, 'h048);
    check("R4 gain untouched", gain, 'h011);
    check("R10 clamp_off", coff, 1);
    check("R10 blank_lvl", blvl, 1);
    check("R10 pwr normal", pmode, 0);
    write1(3'd0, 12'h004);
    check("R10 pwr shutdown", pmode, 2);
    write1(3'd0, 12'h002);
    check("R10 pwr standby", pmode, 1);
  endtask

  task automatic t_width();
    write1(3'd2, 12'hFA5);
    check("R9 clamp", clamp, 'hA5);
    write1(3'd3, 12'hFFF);
    check("R9 gain", gain, 'h3FF);
  endtask

  task automatic t_testbit();
    open_frame(1'b1, 3'd3); send_word(12'h001); close_frame();
    check("R8 reserved bit set", gain, 'h3FF);
  endtask

  task automatic t_partial();
    open_frame(1'b0, 3'd2); send_word(12'h011);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    close_frame();
    check("R11 complete word", clamp, 'h11);
    check("R11 partial dropped", gain, 'h3FF);
  endtask

  task automatic t_swreset();
    open_frame(1'b0, 3'd0); send_word(12'h001); send_word(12'h555); close_frame();
    check("R6 oper", oper, 0);
    check("R6 ctrl", ctrl, 0);
    check("R6 clamp", clamp, 128);
    check("R6 gain", gain, 0);
  endtask

  initial begin
    waitc(60000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitc(5); rst = 0; waitc(2);
    t_reset();
    t_lockout();
    t_single();
    t_commit_gate();
    t_autoinc();
    t_high_addr();
    t_width();
    t_testbit();
    t_partial();
    t_swreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule